// File: doc/BRIEF.md
# Register Stack Frame Manager

This block keeps the current frame marker for a stacked general register file. A frame has two sizes: the locals, and the whole frame, which is the locals followed by the outputs. Stacked registers begin at logical register 32 of a 128-entry general register space. They are renamed onto a circular pool of 96 physical registers through a rename base that slides with each procedure call.

On a call, the caller's marker is pushed onto a small LIFO of saved function states, whose top is shown as the previous-function-state value. The callee starts with no locals and with the caller's outputs as its whole frame. The base advances by the caller's local count, so the caller's outputs and the callee's first registers occupy the same physical entries. An allocate strobe resizes the current frame. A return pops the saved marker and moves the base back. A combinational port translates any logical register number into a physical pool index and flags references that fall outside the current frame.

The block also keeps a running total of the registers held by suspended callers. When that total plus the current frame no longer fits in the pool, it raises a spill request for an outside engine. Spilling and filling are not part of this block.

Top module: `rsf_frame_mgr`

## Requirements
- R1: After reset the current locals, frame size, base, saved state, spill request and all three error flags read zero.
- R2: An allocate with locals not above frame size and frame size not above 96 sets both sizes on the next cycle and leaves the base unchanged.
- R3: An allocate with locals above frame size, or frame size above 96, leaves the marker unchanged and pulses `alloc_err_o` for one cycle.
- R4: A call saves the caller's (locals, frame size) as the visible saved state. The new frame has 0 locals and frame size equal to the caller's frame size minus its locals. The base becomes (base + caller locals) mod 96.
- R5: A return restores the marker from the saved state. The base moves back by the restored local count, modulo 96, and the saved state shows the next older entry, or zero when none remains.
- R6: For a logical register L with 32 <= L < 32 + frame size, `preg_valid_o` is 1 and `preg_o` equals (base + L - 32) mod 96. A caller's register 32 + locals + k and the callee's register 32 + k map to the same physical entry.
- R7: For L >= 32 + frame size, `illegal_o` is 1 and `preg_valid_o` is 0. For L < 32, both are 0 and `preg_o` is 0.
- R8: `spill_req_o` is 1 exactly when the sum of the locals of all suspended callers plus the current frame size exceeds 96.
- R9: A call while 8 states are saved pulses `call_err_o` and changes nothing. A return with no saved state pulses `ret_err_o` and changes nothing.
- R10: When strobes coincide, call wins over return and return wins over allocate. Only the winning operation takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| alloc_i | input | 1 | Allocate strobe |
| alloc_sol_i | input | 7 | Requested local count |
| alloc_sof_i | input | 7 | Requested frame size |
| lreg_i | input | 7 | Logical register number to translate |
| cur_sol_o | output | 7 | Current local count |
| cur_sof_o | output | 7 | Current frame size |
| pfs_sol_o | output | 7 | Saved-state local count (top of LIFO) |
| pfs_sof_o | output | 7 | Saved-state frame size (top of LIFO) |
| base_o | output | 7 | Rename base into the physical pool |
| preg_o | output | 7 | Physical pool index for `lreg_i` |
| preg_valid_o | output | 1 | `lreg_i` lies inside the current frame |
| illegal_o | output | 1 | `lreg_i` is stacked but beyond the frame |
| spill_req_o | output | 1 | Active registers exceed the pool |
| alloc_err_o | output | 1 | One-cycle pulse: rejected allocate |
| call_err_o | output | 1 | One-cycle pulse: call with full save LIFO |
| ret_err_o | output | 1 | One-cycle pulse: return with empty save LIFO |

## Verification
Every cycle, the assertions check that locals never exceed the frame size and that the base and any valid physical index stay inside the pool. They also check that a mapped reference is never both valid and illegal, and that a call, a good allocate, a bad allocate and a return each leave the marker in the state their requirement demands. Some behaviour only shows over a sequence of operations, and only the bench scenarios can show it. This covers the physical overlap of caller outputs with callee inputs, wrap-around of the base past the end of the pool, and the spill threshold across nested calls. It also covers how the saved state unwinds through several returns and which strobe wins when several arrive together.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_CALL  = 2'd1,
      OP_RET   = 2'd2,
      OP_ALLOC = 2'd3
   } op_e;

endpackage

// File: rtl/rsf_op_select.sv
module rsf_op_select
   import rsf_pkg::*;
#(
   parameter int FW      = 7,
   parameter int MAX_SOF = 96
) (
   input  logic          call_i,
   input  logic          ret_i,
   input  logic          alloc_i,
   input  logic [FW-1:0] sol_i,
   input  logic [FW-1:0] sof_i,
   output op_e           op_o,
   output logic          alloc_ok_o
);
   localparam int W1 = FW + 1;

   // R10: fixed priority call > return > allocate
   always_comb begin
      if (call_i)       op_o = OP_CALL;
      else if (ret_i)   op_o = OP_RET;
      else if (alloc_i) op_o = OP_ALLOC;
      else              op_o = OP_NONE;
   end

   // R2 / R3: request legality
   always_comb begin
      alloc_ok_o = (sol_i <= sof_i) && ({1'b0, sof_i} <= W1'(MAX_SOF));
   end

endmodule

// File: rtl/rsf_save_stack.sv
module rsf_save_stack #(
   parameter int DEPTH = 8,
   parameter int FW    = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [FW-1:0] push_sol_i,
   input  logic [FW-1:0] push_sof_i,
   output logic [FW-1:0] top_sol_o,
   output logic [FW-1:0] top_sof_o,
   output logic          empty_o,
   output logic          full_o
);
   localparam int EW = 2 * FW;

   initial begin
      assert (DEPTH >= 1) else $error("rsf_save_stack: DEPTH must be at least 1");
   end

   logic [EW-1:0] top_ent;

   generate
      if (DEPTH == 1) begin : g_single
         logic          vld_q;
         logic [EW-1:0] ent_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               ent_q <= '0;
            end else if (push_i) begin
               vld_q <= 1'b1;
               ent_q <= {push_sol_i, push_sof_i};
            end else if (pop_i) begin
               vld_q <= 1'b0;
            end
         end

         always_comb begin
            top_ent = vld_q ? ent_q : '0;
            empty_o = !vld_q;
            full_o  = vld_q;
         end
      end else begin : g_lifo
         localparam int CNTW = $clog2(DEPTH + 1);
         localparam int IW   = $clog2(DEPTH);

         logic [EW-1:0]   mem_q [DEPTH];
         logic [CNTW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (push_i) cnt_q <= cnt_q + 1'b1;
            else if (pop_i)  cnt_q <= cnt_q - 1'b1;
         end

         always_ff @(posedge clk) begin
            if (push_i) mem_q[IW'(cnt_q)] <= {push_sol_i, push_sof_i};
         end

         always_comb begin
            empty_o = (cnt_q == '0);
            full_o  = (cnt_q == CNTW'(DEPTH));
            top_ent = empty_o ? '0 : mem_q[IW'(cnt_q - 1'b1)];
         end

         assert_cnt_bound_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNTW'(DEPTH));
      end
   endgenerate

   always_comb begin
      top_sol_o = top_ent[EW-1:FW];
      top_sof_o = top_ent[FW-1:0];
   end

   assert_push_not_full_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   assert_pop_not_empty_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);

endmodule

// File: rtl/rsf_rename.sv
module rsf_rename #(
   parameter int NUM_GR        = 128,
   parameter int FIRST_STACKED = 32,
   parameter int POOL          = 96,
   parameter int LW            = 7,
   parameter int PW            = 7,
   parameter int FW            = 7
) (
   input  logic [LW-1:0] lreg_i,
   input  logic [PW-1:0] base_i,
   input  logic [FW-1:0] sof_i,
   output logic [PW-1:0] preg_o,
   output logic          valid_o,
   output logic          illegal_o
);
   localparam int XW   = ((LW > FW) ? LW : FW) + 1;
   localparam bit POW2 = ((1 << PW) == POOL);

   initial begin
      assert (FIRST_STACKED < NUM_GR) else $error("rsf_rename: no stacked registers");
   end

   logic          stacked;
   logic          in_frame;
   logic [XW-1:0] idx;
   logic [XW-1:0] sum;
   logic [PW-1:0] wrapped;

   always_comb begin
      stacked   = ({1'b0, lreg_i} >= (LW+1)'(FIRST_STACKED));
      idx       = XW'(lreg_i) - XW'(FIRST_STACKED);
      in_frame  = idx < XW'(sof_i);
      valid_o   = stacked && in_frame;
      illegal_o = stacked && !in_frame;
      sum       = XW'(base_i) + idx;
   end

   generate
      if (POW2) begin : g_mask
         always_comb wrapped = PW'(sum);
      end else begin : g_sub
         always_comb begin
            if (sum >= XW'(POOL)) wrapped = PW'(sum - XW'(POOL));
            else                  wrapped = PW'(sum);
         end
      end
   endgenerate

   always_comb preg_o = valid_o ? wrapped : '0;

endmodule

// File: rtl/rsf_frame_mgr.sv
module rsf_frame_mgr
   import rsf_pkg::*;
#(
   parameter int  NUM_GR        = 128,
   parameter int  FIRST_STACKED = 32,
   parameter int  POOL          = 96,
   parameter int  DEPTH         = 8,
   localparam int FW            = $clog2(POOL + 1),
   localparam int PW            = $clog2(POOL),
   localparam int LW            = $clog2(NUM_GR)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          call_i,
   input  logic          ret_i,
   input  logic          alloc_i,
   input  logic [FW-1:0] alloc_sol_i,
   input  logic [FW-1:0] alloc_sof_i,
   input  logic [LW-1:0] lreg_i,
   output logic [FW-1:0] cur_sol_o,
   output logic [FW-1:0] cur_sof_o,
   output logic [FW-1:0] pfs_sol_o,
   output logic [FW-1:0] pfs_sof_o,
   output logic [PW-1:0] base_o,
   output logic [PW-1:0] preg_o,
   output logic          preg_valid_o,
   output logic          illegal_o,
   output logic          spill_req_o,
   output logic          alloc_err_o,
   output logic          call_err_o,
   output logic          ret_err_o
);
   localparam int SW = FW + 1;
   localparam int CW = $clog2((DEPTH + 1) * POOL + 1);

   initial begin
      assert (POOL >= 2) else $error("rsf_frame_mgr: POOL too small");
      assert (POOL <= NUM_GR - FIRST_STACKED) else $error("rsf_frame_mgr: POOL exceeds stacked range");
      assert (DEPTH >= 1) else $error("rsf_frame_mgr: DEPTH must be at least 1");
   end

   // ---------------------------------------------------------------- state
   logic [FW-1:0] cur_sol_q, cur_sof_q;
   logic [PW-1:0] base_q;
   logic [CW-1:0] committed_q;
   logic          alloc_err_q, call_err_q, ret_err_q;

   // ---------------------------------------------------------------- decode
   op_e  op;
   logic alloc_ok;

   rsf_op_select #(.FW(FW), .MAX_SOF(POOL)) u_sel (
      .call_i     (call_i),
      .ret_i      (ret_i),
      .alloc_i    (alloc_i),
      .sol_i      (alloc_sol_i),
      .sof_i      (alloc_sof_i),
      .op_o       (op),
      .alloc_ok_o (alloc_ok)
   );

   // ---------------------------------------------------------------- save LIFO
   logic          stk_empty, stk_full, push, pop;
   logic [FW-1:0] top_sol, top_sof;

   always_comb begin
      push = (op == OP_CALL) && !stk_full;
      pop  = (op == OP_RET)  && !stk_empty;
   end

   rsf_save_stack #(.DEPTH(DEPTH), .FW(FW)) u_stk (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push),
      .pop_i      (pop),
      .push_sol_i (cur_sol_q),
      .push_sof_i (cur_sof_q),
      .top_sol_o  (top_sol),
      .top_sof_o  (top_sof),
      .empty_o    (stk_empty),
      .full_o     (stk_full)
   );

   // ---------------------------------------------------------------- base arithmetic
   logic [SW-1:0] fwd_sum;
   logic [PW-1:0] base_fwd, base_back;

   always_comb begin
      fwd_sum = SW'(base_q) + SW'(cur_sol_q);
      if (fwd_sum >= SW'(POOL)) base_fwd = PW'(fwd_sum - SW'(POOL));
      else                      base_fwd = PW'(fwd_sum);
      if (SW'(base_q) >= SW'(top_sol)) base_back = PW'(SW'(base_q) - SW'(top_sol));
      else                             base_back = PW'(SW'(base_q) + SW'(POOL) - SW'(top_sol));
   end

   // ---------------------------------------------------------------- marker update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_sol_q   <= '0;
         cur_sof_q   <= '0;
         base_q      <= '0;
         committed_q <= '0;
         alloc_err_q <= 1'b0;
         call_err_q  <= 1'b0;
         ret_err_q   <= 1'b0;
      end else begin
         alloc_err_q <= 1'b0;
         call_err_q  <= 1'b0;
         ret_err_q   <= 1'b0;
         case (op)
            OP_CALL: begin
               if (stk_full) begin
                  call_err_q <= 1'b1;
               end else begin
                  cur_sol_q   <= '0;
                  cur_sof_q   <= cur_sof_q - cur_sol_q;
                  base_q      <= base_fwd;
                  committed_q <= committed_q + CW'(cur_sol_q);
               end
            end
            OP_RET: begin
               if (stk_empty) begin
                  ret_err_q <= 1'b1;
               end else begin
                  cur_sol_q   <= top_sol;
                  cur_sof_q   <= top_sof;
                  base_q      <= base_back;
                  committed_q <= committed_q - CW'(top_sol);
               end
            end
            OP_ALLOC: begin
               if (alloc_ok) begin
                  cur_sol_q <= alloc_sol_i;
                  cur_sof_q <= alloc_sof_i;
               end else begin
                  alloc_err_q <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // ---------------------------------------------------------------- rename
   rsf_rename #(
      .NUM_GR        (NUM_GR),
      .FIRST_STACKED (FIRST_STACKED),
      .POOL          (POOL),
      .LW            (LW),
      .PW            (PW),
      .FW            (FW)
   ) u_ren (
      .lreg_i    (lreg_i),
      .base_i    (base_q),
      .sof_i     (cur_sof_q),
      .preg_o    (preg_o),
      .valid_o   (preg_valid_o),
      .illegal_o (illegal_o)
   );

   // ---------------------------------------------------------------- outputs
   always_comb begin
      cur_sol_o   = cur_sol_q;
      cur_sof_o   = cur_sof_q;
      pfs_sol_o   = top_sol;
      pfs_sof_o   = top_sof;
      base_o      = base_q;
      alloc_err_o = alloc_err_q;
      call_err_o  = call_err_q;
      ret_err_o   = ret_err_q;
      spill_req_o = (committed_q + CW'(cur_sof_q)) > CW'(POOL);
   end

   // ---------------------------------------------------------------- assertions
   assert_sol_le_sof_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      cur_sol_q <= cur_sof_q);

   assert_alloc_apply_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ALLOC && alloc_ok) |=>
         (cur_sol_q == $past(alloc_sol_i) && cur_sof_q == $past(alloc_sof_i) && $stable(base_q)));

   assert_alloc_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ALLOC && !alloc_ok) |=>
         ($stable(cur_sol_q) && $stable(cur_sof_q) && alloc_err_o));

   assert_call_frame_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CALL && !stk_full) |=>
         (cur_sol_q == '0 && cur_sof_q == $past(cur_sof_q - cur_sol_q)
          && pfs_sol_o == $past(cur_sol_q) && pfs_sof_o == $past(cur_sof_q)));

   assert_base_range_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, base_q} < (PW+1)'(POOL));

   assert_ret_restore_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_RET && !stk_empty) |=>
         (cur_sol_q == $past(top_sol) && cur_sof_q == $past(top_sof)));

   assert_map_bound_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      preg_valid_o |-> ({1'b0, preg_o} < (PW+1)'(POOL)));

   assert_map_excl_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({preg_valid_o, illegal_o}));

   assert_call_full_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CALL && stk_full) |=>
         ($stable(base_q) && $stable(cur_sof_q) && call_err_o));

   assert_ret_empty_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_RET && stk_empty) |=>
         ($stable(base_q) && $stable(cur_sol_q) && ret_err_o));

endmodule

// File: tb/rsf_frame_mgr_test.sv
module rsf_frame_mgr_test;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         call_i = 1'b0, ret_i = 1'b0, alloc_i = 1'b0;
   logic [W-1:0] alloc_sol_i = '0, alloc_sof_i = '0, lreg_i = '0;
   logic [W-1:0] cur_sol_o, cur_sof_o, pfs_sol_o, pfs_sof_o, base_o, preg_o;
   logic         preg_valid_o, illegal_o, spill_req_o, alloc_err_o, call_err_o, ret_err_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rsf_frame_mgr uut (
      .clk, .rst_n, .call_i, .ret_i, .alloc_i, .alloc_sol_i, .alloc_sof_i, .lreg_i,
      .cur_sol_o, .cur_sof_o, .pfs_sol_o, .pfs_sof_o, .base_o, .preg_o,
      .preg_valid_o, .illegal_o, .spill_req_o, .alloc_err_o, .call_err_o, .ret_err_o
   );

   task automatic chk(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      call_i = 0; ret_i = 0; alloc_i = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // drive strobes at a falling edge; results visible at the next falling edge
   task automatic strobe(bit c, bit r, bit a, int s, int f);
      @(negedge clk);
      call_i = c; ret_i = r; alloc_i = a;
      alloc_sol_i = W'(s); alloc_sof_i = W'(f);
      @(negedge clk);
      call_i = 0; ret_i = 0; alloc_i = 0;
   endtask

   task automatic frame(string tag, int sol, int sof, int base);
      chk({tag, " sol"},  int'(cur_sol_o), sol);
      chk({tag, " sof"},  int'(cur_sof_o), sof);
      chk({tag, " base"}, int'(base_o),    base);
   endtask

   task automatic saved(string tag, int sol, int sof);
      chk({tag, " pfs_sol"}, int'(pfs_sol_o), sol);
      chk({tag, " pfs_sof"}, int'(pfs_sof_o), sof);
   endtask

   task automatic probe(string tag, int r, int ev, int ei, int ep);
      lreg_i = W'(r);
      #1;
      chk({tag, " valid"},   int'(preg_valid_o), ev);
      chk({tag, " illegal"}, int'(illegal_o),    ei);
      chk({tag, " preg"},    int'(preg_o),       ep);
   endtask

   task automatic t_reset();
      do_reset();
      frame("R1 reset", 0, 0, 0);
      saved("R1 reset", 0, 0);
      chk("R1 spill", int'(spill_req_o), 0);
      chk("R1 errs", int'({alloc_err_o, call_err_o, ret_err_o}), 0);
   endtask

   task automatic t_call_return();
      do_reset();
      strobe(0, 0, 1, 14, 21);
      frame("R2 alloc 14/21", 14, 21, 0);
      probe("R6 r32", 32, 1, 0, 0);
      probe("R6 r52", 52, 1, 0, 20);
      probe("R7 r53", 53, 0, 1, 0);
      probe("R7 r5", 5, 0, 0, 0);
      probe("R6 caller out r46", 46, 1, 0, 14);
      strobe(1, 0, 0, 0, 0);
      frame("R4 call", 0, 7, 14);
      saved("R4 call", 14, 21);
      probe("R6 callee r32", 32, 1, 0, 14);
      probe("R6 callee r38", 38, 1, 0, 20);
      probe("R7 callee r39", 39, 0, 1, 0);
      strobe(0, 0, 1, 16, 19);
      frame("R2 alloc 16/19", 16, 19, 14);
      chk("R2 no err", int'(alloc_err_o), 0);
      probe("R6 r50", 50, 1, 0, 32);
      strobe(0, 0, 1, 20, 19);
      chk("R3 sol>sof err", int'(alloc_err_o), 1);
      frame("R3 sol>sof hold", 16, 19, 14);
      strobe(0, 0, 1, 0, 97);
      chk("R3 sof>96 err", int'(alloc_err_o), 1);
      frame("R3 sof>96 hold", 16, 19, 14);
      @(negedge clk);
      chk("R3 pulse ends", int'(alloc_err_o), 0);
      strobe(1, 0, 0, 0, 0);
      frame("R4 nested call", 0, 3, 30);
      saved("R4 nested call", 16, 19);
      strobe(0, 1, 0, 0, 0);
      frame("R5 ret 1", 16, 19, 14);
      saved("R5 ret 1", 14, 21);
      strobe(0, 1, 0, 0, 0);
      frame("R5 ret 2", 14, 21, 0);
      saved("R5 ret 2", 0, 0);
      strobe(0, 1, 0, 0, 0);
      chk("R9 ret empty err", int'(ret_err_o), 1);
      frame("R9 ret empty hold", 14, 21, 0);
   endtask

   task automatic t_spill_wrap();
      do_reset();
      strobe(0, 0, 1, 0, 96);
      chk("R8 exactly full", int'(spill_req_o), 0);
      strobe(0, 0, 1, 90, 96);
      strobe(1, 0, 0, 0, 0);
      frame("R4 call 90/96", 0, 6, 90);
      chk("R8 96 no spill", int'(spill_req_o), 0);
      probe("R6 r37", 37, 1, 0, 95);
      probe("R7 r38", 38, 0, 1, 0);
      strobe(0, 0, 1, 0, 7);
      chk("R8 97 spill", int'(spill_req_o), 1);
      probe("R6 wrap r38", 38, 1, 0, 0);
      strobe(0, 1, 0, 0, 0);
      frame("R5 ret wrap", 90, 96, 0);
      chk("R8 spill clears", int'(spill_req_o), 0);
   endtask

   task automatic t_stack_full();
      do_reset();
      strobe(0, 0, 1, 1, 2);
      for (int i = 0; i < 8; i++) strobe(1, 0, 0, 0, 0);
      frame("R9 eight calls", 0, 1, 1);
      strobe(0, 0, 1, 0, 1);
      strobe(1, 0, 0, 0, 0);
      chk("R9 call full err", int'(call_err_o), 1);
      frame("R9 call full hold", 0, 1, 1);
      for (int i = 0; i < 8; i++) strobe(0, 1, 0, 0, 0);
      frame("R9 unwound", 1, 2, 0);
      chk("R9 no ret err", int'(ret_err_o), 0);
   endtask

   task automatic t_priority();
      do_reset();
      strobe(0, 0, 1, 2, 5);
      strobe(1, 1, 1, 1, 1);
      frame("R10 call wins", 0, 3, 2);
      saved("R10 call wins", 2, 5);
      strobe(0, 1, 1, 1, 1);
      frame("R10 ret over alloc", 2, 5, 0);
      chk("R10 no alloc err", int'(alloc_err_o), 0);
   endtask

   initial begin
      t_reset();
      t_call_return();
      t_spill_wrap();
      t_stack_full();
      t_priority();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule